// File: doc/BRIEF.md
# Shared Buffer Admission with Dynamic Thresholds

This block is the admission stage of a shared packet buffer. Buffer space is counted in cells of a fixed byte size. For each direction (ingress and egress) the space is divided into a set of pools. Every port and traffic class of a direction is bound to one pool of that direction and owns a limiter: an occupancy counter with a minimum guarantee and a threshold. Each pool is configured either with an absolute cap per limiter or with a cap that tracks the pool's free space.

A request carries a direction, port, class and a packet length in bytes. The block rounds the length up to cells and looks up the bound pool and the limiter settings. It derives the allowed quota and returns a grant or drop one cycle later; on a grant it charges the limiter and the pool at the same clock edge. A release port returns cells when a packet leaves the buffer. In dynamic mode the quota is approximately alpha/(1+alpha) of the pool's free cells, with alpha a power of two picked by a small code. It is computed with shifts only. Configuration is written through a narrow write port, and a read port exposes the occupancy of any class and of the pool it is bound to.

Top module: `sba_admit`

## Requirements
- R1: A byte length L is charged as ceil(L / 96) cells; this holds both for requests and for releases.
- R2: A write with cfg_we_i uses cfg_addr_i = {sel[1:0], dir, port[1:0], class[2:0]}. With sel 0, the pool at the low two address bits gets size = wdata[23:0] and dynamic mode = wdata[24]. With sel 1, the class gets threshold = wdata[23:0] and bound pool = wdata[25:24]. With sel 2, the class gets minimum guarantee = wdata[23:0]. With sel 3, nothing changes. After reset every value is zero: static mode, pool 0.
- R3: With a static pool, a request is granted when the class occupancy plus its cells does not exceed the class threshold and the pool has at least that many free cells. Free cells are size minus occupancy, and zero when occupancy is at or above size.
- R4: With a dynamic pool, the threshold is a code clamped to 1..14. For code c >= 10 the quota is F - (F >> (c-9)). For c < 10 the quota is F >> (11-c), where F is the pool's free cells. A grant needs occupancy plus cells <= quota and F >= cells.
- R5: A request whose class occupancy is below the class minimum guarantee is granted whatever the quota and pool state.
- R6: The decision for a request sampled at edge k is shown on dec_valid_o and dec_grant_o after edge k. dec_valid_o is low when no request was sampled, and dec_grant_o is never high without dec_valid_o.
- R7: A grant adds the cells to the class counter and to the counter of its bound pool at the same edge. A drop leaves both counters unchanged.
- R8: A release subtracts its cells from the class counter and from the pool the class is bound to at that moment. Both counters saturate at zero.
- R9: A grant and a release that hit the same counter in one cycle are both applied at that edge.
- R10: rd_lim_occ_o shows the occupancy of the class selected by rd_dir_i, rd_port_i and rd_tc_i, and rd_pool_occ_o shows the occupancy of the pool that class is bound to. Both are combinational from the current counters. With no request and no release the counters hold.
- R11: Ingress and egress keep separate settings and counters for the same port, class and pool numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Select, direction, port, class (pool in low bits) |
| cfg_wdata_i | input | 26 | Configuration data |
| req_valid_i | input | 1 | Admission request valid |
| req_dir_i | input | 1 | Request direction, 0 ingress, 1 egress |
| req_port_i | input | 2 | Request port |
| req_tc_i | input | 3 | Request traffic class |
| req_len_i | input | 16 | Request length in bytes |
| rel_valid_i | input | 1 | Release valid |
| rel_dir_i | input | 1 | Release direction |
| rel_port_i | input | 2 | Release port |
| rel_tc_i | input | 3 | Release traffic class |
| rel_len_i | input | 16 | Release length in bytes |
| rd_dir_i | input | 1 | Occupancy read direction |
| rd_port_i | input | 2 | Occupancy read port |
| rd_tc_i | input | 3 | Occupancy read class |
| dec_valid_o | output | 1 | Decision valid, one cycle after a request |
| dec_grant_o | output | 1 | Request granted |
| rd_lim_occ_o | output | 24 | Selected class occupancy in cells |
| rd_pool_occ_o | output | 24 | Occupancy of the selected class's pool in cells |

## Verification
The assertions check on every cycle that decisions follow requests by exactly one cycle and that a grant never appears alone. They also check that a dropped request leaves the observed counters unchanged, that a release never makes a counter grow (so no wrap below zero), and that counters hold when idle. Only the bench's scenarios can show the quota arithmetic itself. That covers the cell rounding, the exact static boundary, the dynamic code clamp at both ends, the minimum-guarantee bypass of a full pool, the combined grant and release on one counter, and the separation of directions, each compared against a behavioural model every clock.

// File: rtl/sba_pkg.sv
`timescale 1ns/1ps
package sba_pkg;
  typedef enum logic [1:0] {
    CFG_POOL = 2'd0,
    CFG_BIND = 2'd1,
    CFG_MIN  = 2'd2
  } cfg_sel_e;
endpackage

// File: rtl/sba_cfg.sv
`timescale 1ns/1ps
module sba_cfg import sba_pkg::*; #(
  parameter int NUM_PORTS = 4,
  parameter int NUM_POOLS = 4,
  parameter int NUM_TCS   = 8,
  parameter int OCC_W     = 24,
  localparam int PORT_W = $clog2(NUM_PORTS),
  localparam int TC_W   = $clog2(NUM_TCS),
  localparam int POOL_W = $clog2(NUM_POOLS),
  localparam int NL     = 2 * NUM_PORTS * NUM_TCS,
  localparam int NP     = 2 * NUM_POOLS,
  localparam int LI_W   = $clog2(NL),
  localparam int PI_W   = $clog2(NP),
  localparam int AW     = PORT_W + TC_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [OCC_W+POOL_W-1:0] wdata_i,
  output logic [OCC_W-1:0]  pool_size_o [NP],
  output logic              pool_dyn_o  [NP],
  output logic [POOL_W-1:0] bind_pool_o [NL],
  output logic [OCC_W-1:0]  bind_th_o   [NL],
  output logic [OCC_W-1:0]  bind_min_o  [NL]
);
  cfg_sel_e        sel;
  logic [LI_W-1:0] lidx;
  logic [PI_W-1:0] pidx;

  assign sel  = cfg_sel_e'(addr_i[AW-1 -: 2]);
  assign lidx = addr_i[LI_W-1:0];
  assign pidx = {addr_i[AW-3], addr_i[POOL_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NP; i++) begin
        pool_size_o[i] <= '0;
        pool_dyn_o[i]  <= 1'b0;
      end
      for (int i = 0; i < NL; i++) begin
        bind_pool_o[i] <= '0;
        bind_th_o[i]   <= '0;
        bind_min_o[i]  <= '0;
      end
    end else if (we_i) begin
      case (sel)
        CFG_POOL: begin
          pool_size_o[pidx] <= wdata_i[OCC_W-1:0];
          pool_dyn_o[pidx]  <= wdata_i[OCC_W];
        end
        CFG_BIND: begin
          bind_th_o[lidx]   <= wdata_i[OCC_W-1:0];
          bind_pool_o[lidx] <= wdata_i[OCC_W +: POOL_W];
        end
        CFG_MIN:  bind_min_o[lidx] <= wdata_i[OCC_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sba_quota.sv
`timescale 1ns/1ps
module sba_quota #(
  parameter int OCC_W      = 24,
  parameter int CODE_MIN   = 1,
  parameter int CODE_MAX   = 14,
  parameter int CODE_UNITY = 10
) (
  input  logic [OCC_W-1:0] pool_size_i,
  input  logic [OCC_W-1:0] pool_occ_i,
  input  logic             dyn_i,
  input  logic [OCC_W-1:0] th_i,
  output logic [OCC_W-1:0] free_o,
  output logic [OCC_W-1:0] limit_o
);
  logic [OCC_W-1:0] code, dyn_q;

  always_comb begin
    free_o = (pool_size_i > pool_occ_i) ? pool_size_i - pool_occ_i : '0;
    if (th_i < OCC_W'(CODE_MIN))      code = OCC_W'(CODE_MIN);
    else if (th_i > OCC_W'(CODE_MAX)) code = OCC_W'(CODE_MAX);
    else                              code = th_i;
    // alpha >= 1: keep all but a shrinking slice; alpha < 1: a shrinking slice
    if (code >= OCC_W'(CODE_UNITY))
      dyn_q = free_o - (free_o >> (code - OCC_W'(CODE_UNITY - 1)));
    else
      dyn_q = free_o >> (OCC_W'(CODE_UNITY + 1) - code);
    limit_o = dyn_i ? dyn_q : th_i;
  end
endmodule

// File: rtl/sba_ctr.sv
`timescale 1ns/1ps
module sba_ctr #(
  parameter int OCC_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [OCC_W-1:0] inc_amt_i,
  input  logic             dec_i,
  input  logic [OCC_W-1:0] dec_amt_i,
  output logic [OCC_W-1:0] occ_o
);
  logic [OCC_W:0] up, down;

  always_comb begin
    up   = {1'b0, occ_o} + (inc_i ? {1'b0, inc_amt_i} : '0);
    down = dec_i ? {1'b0, dec_amt_i} : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        occ_o <= '0;
    else if (up > down) occ_o <= OCC_W'(up - down);
    else                occ_o <= '0;
  end
endmodule

// File: rtl/sba_admit.sv
`timescale 1ns/1ps
module sba_admit #(
  parameter int NUM_PORTS  = 4,
  parameter int NUM_POOLS  = 4,
  parameter int NUM_TCS    = 8,
  parameter int CELL_BYTES = 96,
  parameter int OCC_W      = 24,
  parameter int LEN_W      = 16,
  parameter int CODE_MIN   = 1,
  parameter int CODE_MAX   = 14,
  parameter int CODE_UNITY = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_we_i,
  input  logic [$clog2(NUM_PORTS)+$clog2(NUM_TCS)+2:0] cfg_addr_i,
  input  logic [OCC_W+$clog2(NUM_POOLS)-1:0] cfg_wdata_i,
  input  logic req_valid_i,
  input  logic req_dir_i,
  input  logic [$clog2(NUM_PORTS)-1:0] req_port_i,
  input  logic [$clog2(NUM_TCS)-1:0] req_tc_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic rel_valid_i,
  input  logic rel_dir_i,
  input  logic [$clog2(NUM_PORTS)-1:0] rel_port_i,
  input  logic [$clog2(NUM_TCS)-1:0] rel_tc_i,
  input  logic [LEN_W-1:0] rel_len_i,
  input  logic rd_dir_i,
  input  logic [$clog2(NUM_PORTS)-1:0] rd_port_i,
  input  logic [$clog2(NUM_TCS)-1:0] rd_tc_i,
  output logic dec_valid_o,
  output logic dec_grant_o,
  output logic [OCC_W-1:0] rd_lim_occ_o,
  output logic [OCC_W-1:0] rd_pool_occ_o
);
  localparam int POOL_W = $clog2(NUM_POOLS);
  localparam int NL     = 2 * NUM_PORTS * NUM_TCS;
  localparam int NP     = 2 * NUM_POOLS;
  localparam int LI_W   = $clog2(NL);
  localparam int PI_W   = $clog2(NP);

  function automatic logic [OCC_W-1:0] to_cells(input logic [LEN_W-1:0] len);
    logic [LEN_W:0] s;
    s = {1'b0, len} + (LEN_W+1)'(CELL_BYTES - 1);
    return OCC_W'(s / (LEN_W+1)'(CELL_BYTES));
  endfunction

  logic [OCC_W-1:0]  pool_size [NP];
  logic              pool_dyn  [NP];
  logic [POOL_W-1:0] bind_pool [NL];
  logic [OCC_W-1:0]  bind_th   [NL];
  logic [OCC_W-1:0]  bind_min  [NL];
  logic [OCC_W-1:0]  lim_occ   [NL];
  logic [OCC_W-1:0]  pool_occ  [NP];

  logic [LI_W-1:0]  req_li, rel_li, rd_li;
  logic [PI_W-1:0]  req_pi, rel_pi, rd_pi;
  logic [OCC_W-1:0] req_cells, rel_cells, req_free, req_limit, req_occ;
  logic             under_min, fits, room, admit;

  sba_cfg #(
    .NUM_PORTS(NUM_PORTS), .NUM_POOLS(NUM_POOLS), .NUM_TCS(NUM_TCS), .OCC_W(OCC_W)
  ) u_cfg (
    .clk_i, .rst_ni,
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .pool_size_o(pool_size),
    .pool_dyn_o (pool_dyn),
    .bind_pool_o(bind_pool),
    .bind_th_o  (bind_th),
    .bind_min_o (bind_min)
  );

  always_comb begin
    req_li    = {req_dir_i, req_port_i, req_tc_i};
    rel_li    = {rel_dir_i, rel_port_i, rel_tc_i};
    rd_li     = {rd_dir_i, rd_port_i, rd_tc_i};
    req_pi    = {req_dir_i, bind_pool[req_li]};
    rel_pi    = {rel_dir_i, bind_pool[rel_li]};
    rd_pi     = {rd_dir_i, bind_pool[rd_li]};
    req_cells = to_cells(req_len_i);
    rel_cells = to_cells(rel_len_i);
    req_occ   = lim_occ[req_li];
  end

  sba_quota #(
    .OCC_W(OCC_W), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX), .CODE_UNITY(CODE_UNITY)
  ) u_quota (
    .pool_size_i(pool_size[req_pi]),
    .pool_occ_i (pool_occ[req_pi]),
    .dyn_i      (pool_dyn[req_pi]),
    .th_i       (bind_th[req_li]),
    .free_o     (req_free),
    .limit_o    (req_limit)
  );

  always_comb begin
    under_min = req_occ < bind_min[req_li];
    fits      = ({1'b0, req_occ} + {1'b0, req_cells}) <= {1'b0, req_limit};
    room      = req_free >= req_cells;
    admit     = req_valid_i && (under_min || (fits && room));
  end

  for (genvar g = 0; g < NL; g++) begin : g_lim
    sba_ctr #(.OCC_W(OCC_W)) u_ctr (
      .clk_i, .rst_ni,
      .inc_i    (admit && (req_li == LI_W'(g))),
      .inc_amt_i(req_cells),
      .dec_i    (rel_valid_i && (rel_li == LI_W'(g))),
      .dec_amt_i(rel_cells),
      .occ_o    (lim_occ[g])
    );
  end

  for (genvar g = 0; g < NP; g++) begin : g_pool
    sba_ctr #(.OCC_W(OCC_W)) u_ctr (
      .clk_i, .rst_ni,
      .inc_i    (admit && (req_pi == PI_W'(g))),
      .inc_amt_i(req_cells),
      .dec_i    (rel_valid_i && (rel_pi == PI_W'(g))),
      .dec_amt_i(rel_cells),
      .occ_o    (pool_occ[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o <= 1'b0;
      dec_grant_o <= 1'b0;
    end else begin
      dec_valid_o <= req_valid_i;
      dec_grant_o <= admit;
    end
  end

  assign rd_lim_occ_o  = lim_occ[rd_li];
  assign rd_pool_occ_o = pool_occ[rd_pi];
endmodule

// File: rtl/sba_admit_chk.sv
`timescale 1ns/1ps
module sba_admit_chk #(
  parameter int PORT_W = 2,
  parameter int TC_W   = 3,
  parameter int OCC_W  = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic              req_valid_i,
  input logic              rel_valid_i,
  input logic              rd_dir_i,
  input logic [PORT_W-1:0] rd_port_i,
  input logic [TC_W-1:0]   rd_tc_i,
  input logic              dec_valid_o,
  input logic              dec_grant_o,
  input logic [OCC_W-1:0]  rd_lim_occ_o,
  input logic [OCC_W-1:0]  rd_pool_occ_o
);
  AST_DEC_FOLLOWS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> dec_valid_o); // R6
  AST_NO_SPURIOUS_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !dec_valid_o); // R6
  AST_GRANT_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_grant_o |-> dec_valid_o); // R6
  AST_DROP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !rel_valid_i && !cfg_we_i) |=>
      (dec_grant_o || !($stable(rd_dir_i) && $stable(rd_port_i) && $stable(rd_tc_i)) ||
       ($stable(rd_lim_occ_o) && $stable(rd_pool_occ_o)))); // R7
  AST_REL_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_valid_i && !req_valid_i) |=>
      (!($stable(rd_dir_i) && $stable(rd_port_i) && $stable(rd_tc_i)) ||
       (rd_lim_occ_o <= $past(rd_lim_occ_o)))); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i && !rel_valid_i) |=>
      (!($stable(rd_dir_i) && $stable(rd_port_i) && $stable(rd_tc_i)) ||
       $stable(rd_lim_occ_o))); // R10
endmodule

bind sba_admit sba_admit_chk #(
  .PORT_W($clog2(NUM_PORTS)), .TC_W($clog2(NUM_TCS)), .OCC_W(OCC_W)
) u_chk (.*);

// File: tb/sba_admit_test.sv
`timescale 1ns/1ps
module sba_admit_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we_i = 1'b0;
  logic [7:0] cfg_addr_i = '0;
  logic [25:0] cfg_wdata_i = '0;
  logic req_valid_i = 1'b0, req_dir_i = 1'b0;
  logic [1:0] req_port_i = '0;
  logic [2:0] req_tc_i = '0;
  logic [15:0] req_len_i = '0;
  logic rel_valid_i = 1'b0, rel_dir_i = 1'b0;
  logic [1:0] rel_port_i = '0;
  logic [2:0] rel_tc_i = '0;
  logic [15:0] rel_len_i = '0;
  logic rd_dir_i = 1'b0;
  logic [1:0] rd_port_i = '0;
  logic [2:0] rd_tc_i = '0;
  logic dec_valid_o, dec_grant_o;
  logic [23:0] rd_lim_occ_o, rd_pool_occ_o;

  sba_admit uut (.*);

  always #5 clk_i = ~clk_i;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural model
  int psize [2][4];
  bit pdyn  [2][4];
  int pocc  [2][4];
  int bpool [2][4][8];
  int bth   [2][4][8];
  int bmin  [2][4][8];
  int locc  [2][4][8];

  function automatic int cells_of(int len);
    return (len + 95) / 96;
  endfunction

  function automatic int quota(int fr, int th);
    int code;
    code = (th < 1) ? 1 : ((th > 14) ? 14 : th);
    if (code >= 10) return fr - (fr >> (code - 9));
    return fr >> (11 - code);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle(input string tag);
    int d, p, t, c, pl, fr, lim, xd, xp, xt, xc, xpl, sel, cd, cp, ct, cpl;
    bit g;
    bit v;
    v = req_valid_i;
    g = 0;
    d = req_dir_i; p = req_port_i; t = req_tc_i; c = cells_of(req_len_i);
    pl = bpool[d][p][t];
    xd = rel_dir_i; xp = rel_port_i; xt = rel_tc_i; xc = cells_of(rel_len_i);
    xpl = bpool[xd][xp][xt];
    if (v) begin
      fr  = (psize[d][pl] > pocc[d][pl]) ? psize[d][pl] - pocc[d][pl] : 0;
      lim = pdyn[d][pl] ? quota(fr, bth[d][p][t]) : bth[d][p][t];
      g = (locc[d][p][t] < bmin[d][p][t]) || ((locc[d][p][t] + c <= lim) && (fr >= c));
    end
    if (g) begin
      locc[d][p][t] += c;
      pocc[d][pl]   += c;
    end
    if (rel_valid_i) begin
      locc[xd][xp][xt] = (locc[xd][xp][xt] > xc) ? locc[xd][xp][xt] - xc : 0;
      pocc[xd][xpl]    = (pocc[xd][xpl] > xc) ? pocc[xd][xpl] - xc : 0;
    end
    if (cfg_we_i) begin
      sel = cfg_addr_i[7:6]; cd = cfg_addr_i[5]; cp = cfg_addr_i[4:3];
      ct = cfg_addr_i[2:0]; cpl = cfg_addr_i[1:0];
      if (sel == 0) begin
        psize[cd][cpl] = cfg_wdata_i[23:0];
        pdyn[cd][cpl]  = cfg_wdata_i[24];
      end else if (sel == 1) begin
        bth[cd][cp][ct]   = cfg_wdata_i[23:0];
        bpool[cd][cp][ct] = cfg_wdata_i[25:24];
      end else if (sel == 2) begin
        bmin[cd][cp][ct] = cfg_wdata_i[23:0];
      end
    end
    @(posedge clk_i);
    #1;
    chk({tag, " R6 dec_valid"}, dec_valid_o, v);
    chk({tag, " grant"}, dec_grant_o, g);
    chk({tag, " R10 lim_occ"}, rd_lim_occ_o, locc[rd_dir_i][rd_port_i][rd_tc_i]);
    chk({tag, " R10 pool_occ"}, rd_pool_occ_o,
        pocc[rd_dir_i][bpool[rd_dir_i][rd_port_i][rd_tc_i]]);
  endtask

  task automatic rd_at(input int d, input int p, input int t);
    rd_dir_i = d[0]; rd_port_i = p[1:0]; rd_tc_i = t[2:0];
  endtask

  task automatic cfg_pool(input int d, input int pl, input int size, input int dyn, input string tag);
    cfg_we_i = 1; cfg_addr_i = {2'd0, d[0], 3'b000, pl[1:0]};
    cfg_wdata_i = {1'b0, dyn[0], size[23:0]};
    cycle(tag);
    cfg_we_i = 0;
  endtask

  task automatic cfg_bind(input int d, input int p, input int t, input int pl, input int th, input string tag);
    cfg_we_i = 1; cfg_addr_i = {2'd1, d[0], p[1:0], t[2:0]};
    cfg_wdata_i = {pl[1:0], th[23:0]};
    cycle(tag);
    cfg_we_i = 0;
  endtask

  task automatic cfg_min(input int d, input int p, input int t, input int mn, input string tag);
    cfg_we_i = 1; cfg_addr_i = {2'd2, d[0], p[1:0], t[2:0]};
    cfg_wdata_i = {2'b00, mn[23:0]};
    cycle(tag);
    cfg_we_i = 0;
  endtask

  task automatic req(input int d, input int p, input int t, input int len, input string tag);
    req_valid_i = 1; req_dir_i = d[0]; req_port_i = p[1:0]; req_tc_i = t[2:0];
    req_len_i = len[15:0];
    rd_at(d, p, t);
    cycle(tag);
    req_valid_i = 0;
  endtask

  task automatic rel(input int d, input int p, input int t, input int len, input string tag);
    rel_valid_i = 1; rel_dir_i = d[0]; rel_port_i = p[1:0]; rel_tc_i = t[2:0];
    rel_len_i = len[15:0];
    rd_at(d, p, t);
    cycle(tag);
    rel_valid_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(11));
    repeat (3) @(posedge clk_i);
    #1;
    chk("R6 reset dec_valid", dec_valid_o, 0);
    chk("R10 reset lim_occ", rd_lim_occ_o, 0);
    chk("R10 reset pool_occ", rd_pool_occ_o, 0);
    rst_ni = 1;
    cycle("R10 idle");

    // R3 static limit with R1 rounding
    cfg_pool(0, 0, 1000, 0, "R2 pool");
    cfg_bind(0, 1, 2, 0, 10, "R2 bind");
    req(0, 1, 2, 96, "R1 exact cell");
    req(0, 1, 2, 97, "R1 round up");
    chk("R1 two cells charged", rd_lim_occ_o, 3);
    req(0, 1, 2, 1, "R1 one byte");
    req(0, 1, 2, 672, "R3 over threshold");
    chk("R3 drop over threshold", dec_grant_o, 0);
    chk("R7 drop keeps occ", rd_lim_occ_o, 4);
    req(0, 1, 2, 576, "R3 at threshold");
    chk("R3 grant at threshold", dec_grant_o, 1);
    chk("R7 pool charged", rd_pool_occ_o, 10);

    // R3 pool free space
    cfg_pool(0, 1, 5, 0, "R2 pool1");
    cfg_bind(0, 0, 0, 1, 100, "R2 bind");
    req(0, 0, 0, 480, "R3 fill pool");
    chk("R3 grant fills pool", dec_grant_o, 1);
    req(0, 0, 0, 1, "R3 pool full");
    chk("R3 drop on full pool", dec_grant_o, 0);

    // R5 minimum guarantee
    cfg_bind(0, 2, 3, 1, 0, "R2 bind");
    cfg_min(0, 2, 3, 2, "R2 min");
    req(0, 2, 3, 96, "R5 under min a");
    chk("R5 grant under min", dec_grant_o, 1);
    req(0, 2, 3, 96, "R5 under min b");
    chk("R5 grant under min", dec_grant_o, 1);
    req(0, 2, 3, 96, "R5 at min");
    chk("R5 drop at min", dec_grant_o, 0);

    // R4 dynamic quota
    cfg_pool(1, 2, 1024, 1, "R2 dyn pool");
    cfg_bind(1, 3, 7, 2, 10, "R2 bind");
    req(1, 3, 7, 49152, "R4 alpha one");
    chk("R4 grant at half free", dec_grant_o, 1);
    req(1, 3, 7, 96, "R4 quota shrinks");
    chk("R4 drop after quota", dec_grant_o, 0);
    cfg_bind(1, 3, 6, 2, 20, "R2 bind");
    req(1, 3, 6, 47616, "R4 clamp high");
    chk("R4 grant clamp 14", dec_grant_o, 1);
    chk("R4 pool after clamp", rd_pool_occ_o, 1008);
    cfg_bind(1, 3, 5, 2, 0, "R2 bind");
    req(1, 3, 5, 96, "R4 clamp low");
    chk("R4 drop clamp 1", dec_grant_o, 0);

    // R11 direction separation
    req(0, 3, 7, 96, "R11 ingress unbound");
    chk("R11 ingress drop", dec_grant_o, 0);
    rd_at(1, 3, 7);
    cycle("R11 egress view");
    chk("R11 egress occ kept", rd_lim_occ_o, 512);

    // R8 release with saturation
    rel(0, 1, 2, 384, "R8 release");
    chk("R8 release lim", rd_lim_occ_o, 6);
    rel(0, 1, 2, 4800, "R8 saturate");
    chk("R8 lim at zero", rd_lim_occ_o, 0);
    chk("R8 pool at zero", rd_pool_occ_o, 0);

    // R9 same-cycle grant and release
    req_valid_i = 1; req_dir_i = 0; req_port_i = 1; req_tc_i = 2; req_len_i = 288;
    rel_valid_i = 1; rel_dir_i = 0; rel_port_i = 1; rel_tc_i = 2; rel_len_i = 96;
    rd_at(0, 1, 2);
    cycle("R9 both");
    req_valid_i = 0; rel_valid_i = 0;
    chk("R9 lim net", rd_lim_occ_o, 2);
    chk("R9 pool net", rd_pool_occ_o, 2);

    // R2 select 3 ignored
    cfg_we_i = 1; cfg_addr_i = {2'd3, 1'b0, 2'd1, 3'd2}; cfg_wdata_i = 26'h3ffffff;
    cycle("R2 sel3");
    cfg_we_i = 0;
    req(0, 1, 2, 96, "R2 sel3 no effect");
    chk("R2 sel3 threshold kept", dec_grant_o, 1);

    // mixed traffic against the model
    for (int i = 0; i < 4000; i++) begin
      cfg_we_i    = ($urandom % 20) == 0;
      cfg_addr_i  = 8'($urandom);
      cfg_wdata_i = {2'($urandom), 1'($urandom), 23'(($urandom % 2 == 0) ? ($urandom % 20) : ($urandom % 3000))};
      req_valid_i = ($urandom % 10) < 6;
      req_dir_i = 1'($urandom); req_port_i = 2'($urandom); req_tc_i = 3'($urandom);
      req_len_i = 16'($urandom % 3000);
      rel_valid_i = ($urandom % 10) < 4;
      rel_dir_i = 1'($urandom); rel_port_i = 2'($urandom); rel_tc_i = 3'($urandom);
      rel_len_i = 16'($urandom % 3000);
      if ($urandom % 2 == 0) rd_at(req_dir_i, req_port_i, req_tc_i);
      else rd_at(rel_dir_i, rel_port_i, rel_tc_i);
      cycle("R3 R4 R5 R7 R8 R9 mixed");
    end
    cfg_we_i = 0; req_valid_i = 0; rel_valid_i = 0;
    cycle("R10 final idle");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule